// File: doc/BRIEF.md
# Integer Execute Unit with Barrel Shifter

This block is the integer execute stage of a small load/store processor core. It sees the two register values an instruction has read (first and second source), the instruction's 16-bit immediate, its 5-bit constant shift field, the two candidate destination indices and a 5-bit operation code. It returns the 32-bit result, the destination index to write, a write-enable, an arithmetic-overflow flag and an unknown-operation flag.

All outputs are combinational functions of the current inputs, with no register inside. The surrounding pipeline owns the register file and any exception handling. It writes `wb_data` to `wb_idx` only when `wb_en` is high. When `ovf_trap` or `bad_op` is high it starts its own exception sequence. Because nothing is stored, the block has no stream handshake: the core holds the inputs steady for as long as it needs the outputs.

Top module: `alu_exec_unit`

## Requirements
- R1: Operation codes 0 (OR) and 2 (XOR) give the bitwise OR and XOR of `src_a` and `src_b`, with `wb_en`=1.
- R2: Operation codes 1 (OR-immediate) and 3 (XOR-immediate) combine `src_a` with the immediate zero-extended to 32 bits, so a negative-looking immediate never sets bits 31..16 of the result.
- R3: Code 4 (signed less-than against `src_b`) and code 5 (signed less-than against the sign-extended immediate) give 1 when `src_a` is smaller as a two's-complement number and 0 otherwise. Bits 31..1 are always zero.
- R4: Code 6 (unsigned less-than against `src_b`) and code 7 (unsigned less-than against the immediate) compare as unsigned 32-bit numbers. For code 7 the immediate is sign-extended first, so the value 0xFFFF stands for 0xFFFFFFFF.
- R5: Constant shifts shift `src_b` by `shamt_f`: code 8 shifts left, code 10 shifts right logically and code 12 shifts right arithmetically.
- R6: Variable shifts (code 9 left, code 11 right logical, code 13 right arithmetic) shift `src_b` by `src_a[4:0]` and ignore `src_a[31:5]`.
- R7: A right arithmetic shift fills the vacated bits with `src_b[31]`. A right logical shift fills them with zeros.
- R8: Code 14 (trapping subtract) raises `ovf_trap` exactly when the signs of `src_a` and `src_b` differ and the sign of `src_a - src_b` differs from the sign of `src_a`. While `ovf_trap` is raised, `wb_en` is 0. Otherwise the result is the difference and `wb_en` is 1.
- R9: Code 15 (wrapping subtract) returns `src_a - src_b` modulo 2^32 with `wb_en`=1 and never raises `ovf_trap`.
- R10: `wb_idx` equals `rt_idx` for the immediate forms (codes 1, 3, 5, 7) and equals `rd_idx` for every other defined code.
- R11: Codes 16 to 31 raise `bad_op` and give `wb_en`=0, `ovf_trap`=0, `wb_data`=0 and `wb_idx`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 5 | Operation code (see requirements) |
| src_a | input | 32 | First source register value |
| src_b | input | 32 | Second source register value |
| imm_f | input | 16 | Instruction immediate field |
| shamt_f | input | 5 | Constant shift amount field |
| rt_idx | input | 5 | Second-source register index, used as destination by immediate forms |
| rd_idx | input | 5 | Destination index for register forms |
| wb_data | output | 32 | Result value |
| wb_idx | output | 5 | Destination register index |
| wb_en | output | 1 | Register write enable |
| ovf_trap | output | 1 | Signed overflow on trapping subtract |
| bad_op | output | 1 | Operation code not defined |

## Verification
The assertions are evaluated whenever the combinational outputs settle. They assume that every input carries a known 0/1 value, so an undefined operation code is a real code from 16 to 31 and not an X. The stimulus drives every one of the 32 codes against a fixed set of corner operands: zero, one, all-ones, the extreme signed values, values with set upper bits for the variable shift amount, and immediates with bit 15 both set and clear. It never leaves an input undriven. Each vector is held for a full clock period before the outputs are compared.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;

  typedef enum logic [4:0] {
    OP_OR    = 5'd0,
    OP_ORI   = 5'd1,
    OP_XOR   = 5'd2,
    OP_XORI  = 5'd3,
    OP_SLT   = 5'd4,
    OP_SLTI  = 5'd5,
    OP_SLTU  = 5'd6,
    OP_SLTIU = 5'd7,
    OP_SHL   = 5'd8,
    OP_SHLV  = 5'd9,
    OP_SHRL  = 5'd10,
    OP_SHRLV = 5'd11,
    OP_SHRA  = 5'd12,
    OP_SHRAV = 5'd13,
    OP_SUBT  = 5'd14,
    OP_SUBW  = 5'd15
  } alu_op_e;

  localparam int unsigned NUM_DEFINED_OPS = 16;

endpackage

// File: rtl/alu_imm_ext.sv
module alu_imm_ext #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic [IMM_W-1:0] imm_in,
  output logic [XLEN-1:0]  imm_zext,
  output logic [XLEN-1:0]  imm_sext
);
  localparam int PAD_W = XLEN - IMM_W;

  assign imm_zext = {{PAD_W{1'b0}}, imm_in};
  assign imm_sext = {{PAD_W{imm_in[IMM_W-1]}}, imm_in};
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] din,
  input  logic [SHW-1:0]  amt,
  input  logic            dir_left,
  input  logic            arith,
  output logic [XLEN-1:0] dout
);
  logic [XLEN-1:0] pre;
  logic [XLEN-1:0] post;
  logic            fill;
  logic [XLEN-1:0] stage [SHW+1];

  // Left shifts reuse the right-shift network on a bit-reversed word.
  for (genvar i = 0; i < XLEN; i++) begin : g_rev_in
    assign pre[i] = dir_left ? din[XLEN-1-i] : din[i];
  end

  assign fill     = arith & ~dir_left & din[XLEN-1];
  assign stage[0] = pre;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int D = 1 << s;
    assign stage[s+1] = amt[s] ? {{D{fill}}, stage[s][XLEN-1:D]} : stage[s];
  end

  assign post = stage[SHW];

  for (genvar i = 0; i < XLEN; i++) begin : g_rev_out
    assign dout[i] = dir_left ? post[XLEN-1-i] : post[i];
  end
endmodule

// File: rtl/alu_cmp_sub.sv
module alu_cmp_sub #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] lhs,
  input  logic [XLEN-1:0] cmp_rhs,
  input  logic [XLEN-1:0] sub_rhs,
  output logic            lt_signed,
  output logic            lt_unsigned,
  output logic [XLEN-1:0] diff,
  output logic            sub_ovf
);
  logic [XLEN:0] cmp_wide;
  logic          sign_mismatch;

  // One wide subtract gives the unsigned borrow; the signed result flips it when signs differ.
  assign cmp_wide      = {1'b0, lhs} - {1'b0, cmp_rhs};
  assign lt_unsigned   = cmp_wide[XLEN];
  assign sign_mismatch = lhs[XLEN-1] ^ cmp_rhs[XLEN-1];
  assign lt_signed     = sign_mismatch ? lhs[XLEN-1] : cmp_wide[XLEN];

  assign diff    = lhs - sub_rhs;
  assign sub_ovf = (lhs[XLEN-1] ^ sub_rhs[XLEN-1]) & (diff[XLEN-1] ^ lhs[XLEN-1]);
endmodule

// File: rtl/alu_exec_unit.sv
module alu_exec_unit
  import alu_exec_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int IDX_W = 5,
  localparam int SHW  = $clog2(XLEN),
  localparam int OP_W = 5
) (
  input  logic [OP_W-1:0]  op_sel,
  input  logic [XLEN-1:0]  src_a,
  input  logic [XLEN-1:0]  src_b,
  input  logic [IMM_W-1:0] imm_f,
  input  logic [SHW-1:0]   shamt_f,
  input  logic [IDX_W-1:0] rt_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [XLEN-1:0]  wb_data,
  output logic [IDX_W-1:0] wb_idx,
  output logic             wb_en,
  output logic             ovf_trap,
  output logic             bad_op
);
  logic [XLEN-1:0] imm_z, imm_s;
  logic [XLEN-1:0] cmp_rhs;
  logic            lt_s, lt_u, sub_ovf;
  logic [XLEN-1:0] diff;
  logic [XLEN-1:0] sh_out;
  logic [SHW-1:0]  sh_amt;
  logic            sh_left, sh_arith, sh_var;
  logic            imm_form;

  alu_imm_ext #(.XLEN(XLEN), .IMM_W(IMM_W)) u_ext (
    .imm_in   (imm_f),
    .imm_zext (imm_z),
    .imm_sext (imm_s)
  );

  assign imm_form = (op_sel == OP_ORI) || (op_sel == OP_XORI) ||
                    (op_sel == OP_SLTI) || (op_sel == OP_SLTIU);
  assign cmp_rhs  = imm_form ? imm_s : src_b;

  alu_cmp_sub #(.XLEN(XLEN)) u_cmp (
    .lhs         (src_a),
    .cmp_rhs     (cmp_rhs),
    .sub_rhs     (src_b),
    .lt_signed   (lt_s),
    .lt_unsigned (lt_u),
    .diff        (diff),
    .sub_ovf     (sub_ovf)
  );

  // Shift codes 8..13: bit0 picks variable amount, bits 2:1 pick direction/kind.
  assign sh_var   = op_sel[0];
  assign sh_left  = (op_sel == OP_SHL) || (op_sel == OP_SHLV);
  assign sh_arith = (op_sel == OP_SHRA) || (op_sel == OP_SHRAV);
  assign sh_amt   = sh_var ? src_a[SHW-1:0] : shamt_f;

  alu_shifter #(.XLEN(XLEN)) u_shift (
    .din      (src_b),
    .amt      (sh_amt),
    .dir_left (sh_left),
    .arith    (sh_arith),
    .dout     (sh_out)
  );

  always_comb begin
    wb_data  = '0;
    wb_idx   = rd_idx;
    wb_en    = 1'b1;
    ovf_trap = 1'b0;
    bad_op   = 1'b0;
    unique case (op_sel)
      OP_OR:    wb_data = src_a | src_b;
      OP_XOR:   wb_data = src_a ^ src_b;
      OP_ORI:   begin wb_data = src_a | imm_z; wb_idx = rt_idx; end
      OP_XORI:  begin wb_data = src_a ^ imm_z; wb_idx = rt_idx; end
      OP_SLT:   wb_data = {{(XLEN-1){1'b0}}, lt_s};
      OP_SLTU:  wb_data = {{(XLEN-1){1'b0}}, lt_u};
      OP_SLTI:  begin wb_data = {{(XLEN-1){1'b0}}, lt_s}; wb_idx = rt_idx; end
      OP_SLTIU: begin wb_data = {{(XLEN-1){1'b0}}, lt_u}; wb_idx = rt_idx; end
      OP_SHL, OP_SHLV, OP_SHRL, OP_SHRLV, OP_SHRA, OP_SHRAV:
                wb_data = sh_out;
      OP_SUBT:  begin
                  wb_data  = diff;
                  ovf_trap = sub_ovf;
                  wb_en    = ~sub_ovf;
                end
      OP_SUBW:  wb_data = diff;
      default:  begin
                  wb_idx = '0;
                  wb_en  = 1'b0;
                  bad_op = 1'b1;
                end
    endcase
  end
endmodule

// File: rtl/alu_exec_chk.sv
module alu_exec_chk #(
  parameter int XLEN  = 32,
  parameter int IDX_W = 5,
  parameter int SHW   = 5
) (
  input logic [4:0]       op_sel,
  input logic [XLEN-1:0]  src_b,
  input logic [SHW-1:0]   shamt_f,
  input logic [IDX_W-1:0] rt_idx,
  input logic [XLEN-1:0]  wb_data,
  input logic [IDX_W-1:0] wb_idx,
  input logic             wb_en,
  input logic             ovf_trap,
  input logic             bad_op
);
  always_comb begin
    // R8
    trap_blocks_write_chk: assert (!(ovf_trap && wb_en));
    // R9
    wrap_sub_no_trap_chk: assert (!(op_sel == 5'd15 && ovf_trap));
    // R11
    bad_op_quiet_chk: assert (!bad_op || (!wb_en && !ovf_trap && wb_data == '0));
    // R11
    bad_op_range_chk: assert (bad_op == (op_sel >= 5'd16));
    // R3
    slt_bool_chk: assert (!(op_sel >= 5'd4 && op_sel <= 5'd7) || wb_data[XLEN-1:1] == '0);
    // R7
    srl_zero_fill_chk: assert (!(op_sel == 5'd10 && shamt_f != '0) || !wb_data[XLEN-1]);
    // R7
    sra_sign_fill_chk: assert (!(op_sel == 5'd12 && shamt_f != '0) || wb_data[XLEN-1] == src_b[XLEN-1]);
    // R10
    imm_dest_chk: assert (!(op_sel inside {5'd1, 5'd3, 5'd5, 5'd7}) || wb_idx == rt_idx);
  end
endmodule

bind alu_exec_unit alu_exec_chk #(.XLEN(XLEN), .IDX_W(IDX_W), .SHW(SHW)) chk_i (
  .op_sel   (op_sel),
  .src_b    (src_b),
  .shamt_f  (shamt_f),
  .rt_idx   (rt_idx),
  .wb_data  (wb_data),
  .wb_idx   (wb_idx),
  .wb_en    (wb_en),
  .ovf_trap (ovf_trap),
  .bad_op   (bad_op)
);

// File: tb/alu_exec_unit_tb_top.sv
module alu_exec_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 150000;

  logic        clk = 1'b0;
  logic [4:0]  op_sel;
  logic [31:0] src_a, src_b;
  logic [15:0] imm_f;
  logic [4:0]  shamt_f, rt_idx, rd_idx;
  logic [31:0] wb_data;
  logic [4:0]  wb_idx;
  logic        wb_en, ovf_trap, bad_op;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_exec_unit dut_i (
    .op_sel, .src_a, .src_b, .imm_f, .shamt_f, .rt_idx, .rd_idx,
    .wb_data, .wb_idx, .wb_en, .ovf_trap, .bad_op
  );

  function automatic logic [31:0] pick_val(input int i);
    case (i)
      0: return 32'h0000_0000;  1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;  3: return 32'h7FFF_FFFF;
      4: return 32'h8000_0000;  5: return 32'h8000_0001;
      6: return 32'h0000_FFFF;  7: return 32'hFFFF_8000;
      8: return 32'h1234_5678;  9: return 32'hA5A5_5A3F;
      10: return 32'hFFFF_FFE4; default: return 32'h0000_0021;
    endcase
  endfunction

  function automatic string tag_of(input logic [4:0] op);
    case (op)
      5'd0, 5'd2: return "R1";
      5'd1, 5'd3: return "R2";
      5'd4, 5'd5: return "R3";
      5'd6, 5'd7: return "R4";
      5'd8: return "R5";
      5'd9, 5'd11, 5'd13: return "R6";
      5'd10, 5'd12: return "R7";
      5'd14: return "R8";
      5'd15: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic model(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input logic [4:0] sh, input logic [4:0] rt,
                       input logic [4:0] rd, output logic [31:0] r, output logic [4:0] idx,
                       output logic we, output logic ov, output logic rs);
    logic [31:0] zx, sx;
    longint d;
    zx = {16'h0000, im};
    sx = {{16{im[15]}}, im};
    r = 32'h0; idx = rd; we = 1'b1; ov = 1'b0; rs = 1'b0;
    case (op)
      5'd0: r = a | b;
      5'd1: begin r = a | zx; idx = rt; end
      5'd2: r = a ^ b;
      5'd3: begin r = a ^ zx; idx = rt; end
      5'd4: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      5'd5: begin r = ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0; idx = rt; end
      5'd6: r = (a < b) ? 32'd1 : 32'd0;
      5'd7: begin r = (a < sx) ? 32'd1 : 32'd0; idx = rt; end
      5'd8: r = b << sh;
      5'd9: r = b << a[4:0];
      5'd10: r = b >> sh;
      5'd11: r = b >> a[4:0];
      5'd12: r = $unsigned($signed(b) >>> sh);
      5'd13: r = $unsigned($signed(b) >>> a[4:0]);
      5'd14: begin
        d = longint'($signed(a)) - longint'($signed(b));
        r = a - b;
        ov = (d > 64'sd2147483647) || (d < -64'sd2147483648);
        we = ~ov;
      end
      5'd15: r = a - b;
      default: begin idx = 5'd0; we = 1'b0; rs = 1'b1; end
    endcase
  endtask

  task automatic apply_and_check(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                                 input logic [15:0] im, input logic [4:0] sh,
                                 input logic [4:0] rt, input logic [4:0] rd);
    logic [31:0] er; logic [4:0] ei; logic ew, eo, es;
    op_sel = op; src_a = a; src_b = b; imm_f = im; shamt_f = sh; rt_idx = rt; rd_idx = rd;
    #(CLK_PERIOD);
    model(op, a, b, im, sh, rt, rd, er, ei, ew, eo, es);
    total++;
    if (wb_en !== ew || ovf_trap !== eo || bad_op !== es || wb_idx !== ei ||
        ((ew || es) && wb_data !== er)) begin
      bad++;
      $display("FAIL %s op=%0d a=%h b=%h imm=%h sh=%0d: got data=%h idx=%0d en=%b ovf=%b bad=%b exp data=%h idx=%0d en=%b ovf=%b bad=%b (R10 idx)",
               tag_of(op), op, a, b, im, sh, wb_data, wb_idx, wb_en, ovf_trap, bad_op,
               er, ei, ew, eo, es);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > MAX_CYCLES && !done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog: got cycles=%0d exp <=%0d", cycles, MAX_CYCLES);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // Initial state with all-zero inputs: OR of zeros, write to index 0 (R1).
    apply_and_check(5'd0, 32'h0, 32'h0, 16'h0, 5'd0, 5'd0, 5'd0);
    // Explicit corners: R2 zero-extend, R4 sign-extended unsigned immediate, R8 overflow.
    apply_and_check(5'd1, 32'h0, 32'h0, 16'h8001, 5'd0, 5'd3, 5'd9);
    apply_and_check(5'd7, 32'hFFFF_FFFE, 32'h0, 16'hFFFF, 5'd0, 5'd3, 5'd9);
    apply_and_check(5'd14, 32'h8000_0000, 32'h0000_0001, 16'h0, 5'd0, 5'd3, 5'd9);
    apply_and_check(5'd15, 32'h8000_0000, 32'h0000_0001, 16'h0, 5'd0, 5'd3, 5'd9);
    apply_and_check(5'd13, 32'hFFFF_FFE4, 32'h8000_0000, 16'h0, 5'd0, 5'd3, 5'd9);
    // Sweep over every op code, operand pair, immediate and shift amount (R1..R11).
    for (int op = 0; op < 32; op++) begin
      for (int ai = 0; ai < 12; ai++) begin
        for (int bi = 0; bi < 12; bi++) begin
          for (int k = 0; k < 4; k++) begin
            logic [15:0] im;
            logic [4:0] sh;
            case (k)
              0: begin im = 16'h0000; sh = 5'd0;  end
              1: begin im = 16'h7FFF; sh = 5'd1;  end
              2: begin im = 16'h8000; sh = 5'd17; end
              default: begin im = 16'hFFFF; sh = 5'd31; end
            endcase
            apply_and_check(5'(op), pick_val(ai), pick_val(bi), im, sh,
                            5'(k + 4), 5'(31 - k));
          end
        end
      end
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule